// File: doc/BRIEF.md
# Sixteen-bit ALU with NZCV condition flags

This block is the arithmetic and logic stage of a small 16-bit datapath. Two operands and an operation code go in. The result and a writeback-enable come out combinationally in the same cycle. A four-bit condition register is held inside the block and updates on the rising clock edge while the flags-write enable is high. Each operation has its own set of flags that it may change. A bit outside that set keeps its old value, so a later conditional branch still sees the flags an earlier instruction left behind.

The operations are:
- addition
- subtraction used for comparison
- negation
- bitwise AND
- bitwise exclusive-or
- bit test
- arithmetic right shift by an amount taken from the second operand
- move of a register value
- move of an 8-bit immediate

For subtraction-style operations the carry is the inverse of the borrow. Decoding instructions into operands, the register file and memory access all live outside this block.

There is no sequencing state. The only stored state is the condition register, which has two named conditions:
- **reset**: the register is cleared to 0000.
- **update**: on a clock edge with the enable high, the masked bits load from the operation's result.

Top module: `alu16_top`

## Requirements
- R1: The condition register `flags` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. It is 0000 after reset. With `flag_we` high, a clock edge changes only the bits that the current operation defines. N is result bit 15, and Z is 1 exactly when the 16-bit result is zero.
- R2: Add (`op` = 0) returns `opa + opb` modulo 2^16 with `wb_en` = 1. It sets C to the unsigned carry out and V to signed overflow.
- R3: Compare (`op` = 1) puts `opa - opb` on `result` with `wb_en` = 0. It sets N and Z from the difference, C = 1 when no borrow occurs, and V to signed overflow.
- R4: Negate (`op` = 2) returns `0 - opb` with `wb_en` = 1. It sets C = 1 only when no borrow occurs (only for `opb` = 0) and V to signed overflow of the subtraction.
- R5: AND (`op` = 3), exclusive-or (`op` = 4), test (`op` = 5, an AND with `wb_en` = 0) and register move (`op` = 7, result = `opb`) update N and Z only. C and V keep their values.
- R6: Immediate move (`op` = 8) returns `opb[7:0]` zero-extended, with `wb_en` = 1. N becomes 0, Z is set from the 8-bit value, and C and V are kept. `opb[15:8]` is ignored.
- R7: Shift (`op` = 6) with `opb[7:0]` from 1 to 15 returns `opa` shifted right with its sign bit copied in. C becomes the last bit shifted out.
- R8: Shift with `opb[7:0]` = 0 returns `opa` unchanged and leaves C unchanged, whatever `opb[15:8]` holds.
- R9: Shift with `opb[7:0]` of 16 or more fills every result bit with `opa[15]` and sets C to `opa[15]`.
- R10: Shift never changes V. It always updates N and Z.
- R11: With `flag_we` low, `flags` holds its value whatever the operation is.
- R12: Operation codes 9 to 15 give result 0 and `wb_en` = 0, and they change no flag even with `flag_we` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the condition register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 16 | First operand: the destination value, or the value to be shifted |
| opb | input | 16 | Second operand: source value, immediate (low byte) or shift amount (low byte) |
| op | input | 4 | Operation code (see R2 to R12) |
| flag_we | input | 1 | Allows the condition register to update at the next edge |
| result | output | 16 | Combinational result |
| wb_en | output | 1 | High when the result should be written back |
| flags | output | 4 | Condition register {N, Z, C, V} |

## Verification
The two functions that meet in one cycle are the update of some flags and the holding of the others. A logic operation, an immediate move or a zero-amount shift changes N and Z at the same edge where C and V must survive. The stimulus table is therefore chained: before each such operation, an add, compare or negate sets C and V to a distinctive value. The checks then compare the whole four-bit register after the edge, so any retained bit that is lost or any masked bit that is written shows up as a mismatch.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_CMP  = 4'd1,
        OP_NEG  = 4'd2,
        OP_AND  = 4'd3,
        OP_EOR  = 4'd4,
        OP_TST  = 4'd5,
        OP_ASR  = 4'd6,
        OP_MOVR = 4'd7,
        OP_MOVI = 4'd8
    } alu_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        carry = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
    parameter int W     = 16,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             cvalid
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] small_amt;
    logic [SHW-1:0] last_idx;
    logic           big;

    always_comb begin
        small_amt = amt[SHW-1:0];
        last_idx  = small_amt - 1'b1;
        big       = (amt >= AMT_W'(W));
        if (amt == '0) begin
            res    = a;
            cout   = 1'b0;
            cvalid = 1'b0;
        end else if (big) begin
            res    = {W{a[W-1]}};
            cout   = a[W-1];
            cvalid = 1'b1;
        end else begin
            res    = W'($signed(a) >>> small_amt);
            cout   = a[last_idx];
            cvalid = 1'b1;
        end
    end
endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [NF-1:0] mask,
    input  logic [NF-1:0] nxt,
    output logic [NF-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else if (we)
            flags <= (flags & ~mask) | (nxt & mask);
    end

    // R1
    masked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((flags ^ $past(flags)) & ~$past(mask)) == '0));
endmodule

// File: rtl/alu16_top.sv
module alu16_top
    import alu16_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8,
    parameter int AMT_W = 8,
    parameter int NF    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [15:0]  opa,
    input  logic [15:0]  opb,
    input  logic [3:0]   op,
    input  logic         flag_we,
    output logic [15:0]  result,
    output logic         wb_en,
    output logic [3:0]   flags
);
    alu_op_e         op_e;
    logic [W-1:0]    as_a;
    logic            as_sub;
    logic [W-1:0]    as_sum;
    logic            as_c;
    logic            as_v;
    logic [W-1:0]    sh_res;
    logic            sh_c;
    logic            sh_cv;
    logic [NF-1:0]   upd_mask;
    logic [NF-1:0]   nxt_flags;
    logic            c_new;
    logic            v_new;

    assign op_e   = alu_op_e'(op);
    assign as_a   = (op_e == OP_NEG) ? '0 : opa;
    assign as_sub = (op_e != OP_ADD);

    alu16_addsub #(.W(W)) u_addsub (
        .a(as_a), .b(opb), .sub(as_sub),
        .sum(as_sum), .carry(as_c), .ovf(as_v)
    );

    alu16_shifter #(.W(W), .AMT_W(AMT_W)) u_shift (
        .a(opa), .amt(opb[AMT_W-1:0]),
        .res(sh_res), .cout(sh_c), .cvalid(sh_cv)
    );

    always_comb begin
        result   = '0;
        wb_en    = 1'b0;
        upd_mask = '0;
        c_new    = 1'b0;
        v_new    = 1'b0;
        case (op_e)
            OP_ADD, OP_NEG: begin
                result = as_sum; wb_en = 1'b1;
                upd_mask = 4'b1111; c_new = as_c; v_new = as_v;
            end
            OP_CMP: begin
                result = as_sum;
                upd_mask = 4'b1111; c_new = as_c; v_new = as_v;
            end
            OP_AND: begin
                result = opa & opb; wb_en = 1'b1; upd_mask = 4'b1100;
            end
            OP_EOR: begin
                result = opa ^ opb; wb_en = 1'b1; upd_mask = 4'b1100;
            end
            OP_TST: begin
                result = opa & opb; upd_mask = 4'b1100;
            end
            OP_MOVR: begin
                result = opb; wb_en = 1'b1; upd_mask = 4'b1100;
            end
            OP_MOVI: begin
                result = {{(W-IMM_W){1'b0}}, opb[IMM_W-1:0]};
                wb_en = 1'b1; upd_mask = 4'b1100;
            end
            OP_ASR: begin
                result = sh_res; wb_en = 1'b1;
                upd_mask = {2'b11, sh_cv, 1'b0}; c_new = sh_c;
            end
            default: begin
                result = '0;
            end
        endcase
        nxt_flags = {result[W-1], (result == '0), c_new, v_new};
    end

    alu16_flagreg #(.NF(NF)) u_flags (
        .clk(clk), .rst_n(rst_n), .we(flag_we),
        .mask(upd_mask), .nxt(nxt_flags), .flags(flags)
    );

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));

    // R3
    cmp_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd1 || op == 4'd5) |-> !wb_en);

    // R6
    movi_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op == 4'd8) |=> !flags[FLAG_N]);

    // R8
    asr_zero_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op == 4'd6 && opb[7:0] == 8'd0) |=> (flags[FLAG_C] == $past(flags[FLAG_C])));

    // R10
    asr_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op == 4'd6) |=> (flags[FLAG_V] == $past(flags[FLAG_V])));

    // R5
    logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (op == 4'd3 || op == 4'd4 || op == 4'd5 || op == 4'd7))
        |=> (flags[1:0] == $past(flags[1:0])));

    // R12
    undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd8) |=> (flags == $past(flags)));
endmodule

// File: tb/test_alu16_top.sv
module test_alu16_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] res;
        logic        wb;
        logic [3:0]  fl;
    } vec_t;

    // flags expected after each entry, chained from 0000 after reset
    localparam vec_t TBL [NVEC] = '{
        '{4'd0, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 4'b1001}, // R2 signed ovf
        '{4'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'b0110}, // R2 carry
        '{4'd3, 16'hF0F0, 16'h8F00, 16'h8000, 1'b1, 4'b1010}, // R5 and
        '{4'd1, 16'h0005, 16'h0005, 16'h0000, 1'b0, 4'b0110}, // R3 equal
        '{4'd1, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 4'b1000}, // R3 borrow
        '{4'd1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 4'b0011}, // R3 ovf
        '{4'd4, 16'h1234, 16'h1234, 16'h0000, 1'b1, 4'b0111}, // R5 eor
        '{4'd5, 16'h8001, 16'h8000, 16'h8000, 1'b0, 4'b1011}, // R5 tst
        '{4'd2, 16'h5555, 16'h0001, 16'hFFFF, 1'b1, 4'b1000}, // R4
        '{4'd2, 16'h0000, 16'h8000, 16'h8000, 1'b1, 4'b1001}, // R4 ovf
        '{4'd2, 16'h1111, 16'h0000, 16'h0000, 1'b1, 4'b0110}, // R4 zero
        '{4'd8, 16'hFFFF, 16'hAB80, 16'h0080, 1'b1, 4'b0010}, // R6
        '{4'd8, 16'hFFFF, 16'h1200, 16'h0000, 1'b1, 4'b0110}, // R6 zero
        '{4'd7, 16'h0000, 16'h8000, 16'h8000, 1'b1, 4'b1010}, // R5 movr
        '{4'd0, 16'h4000, 16'h4000, 16'h8000, 1'b1, 4'b1001}, // R2 set V
        '{4'd6, 16'h8010, 16'h0004, 16'hF801, 1'b1, 4'b1001}, // R7 R10
        '{4'd6, 16'h0003, 16'h0001, 16'h0001, 1'b1, 4'b0011}, // R7
        '{4'd6, 16'h0001, 16'h0001, 16'h0000, 1'b1, 4'b0111}, // R7 zero
        '{4'd6, 16'h8000, 16'h0100, 16'h8000, 1'b1, 4'b1011}, // R8
        '{4'd6, 16'h4000, 16'h0010, 16'h0000, 1'b1, 4'b0101}, // R9
        '{4'd6, 16'h8000, 16'h00FF, 16'hFFFF, 1'b1, 4'b1011}, // R9
        '{4'd6, 16'h4000, 16'h000F, 16'h0000, 1'b1, 4'b0111}, // R7 by 15
        '{4'd0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 4'b0111}  // R2 both
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [3:0]  op = '0;
    logic        flag_we = 1'b0;
    logic [15:0] result;
    logic        wb_en;
    logic [3:0]  flags;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_top i_alu16_top (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op),
        .flag_we(flag_we), .result(result), .wb_en(wb_en), .flags(flags)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check comb outputs, then flags after next edge
    task automatic step(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                        input logic we, input logic [15:0] er, input logic ew,
                        input logic [3:0] ef, input string req);
        @(negedge clk);
        op = o; opa = a; opb = b; flag_we = we;
        #1;
        chk({req, " result"}, result, er);
        chk({req, " wb_en"}, {15'd0, wb_en}, {15'd0, ew});
        @(posedge clk);
        @(negedge clk);
        flag_we = 1'b0;
        chk({req, " flags"}, {12'd0, flags}, {12'd0, ef});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset flags", {12'd0, flags}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i].op, TBL[i].a, TBL[i].b, 1'b1, TBL[i].res, TBL[i].wb, TBL[i].fl,
                 $sformatf("R1 vec%0d", i));
        end

        // R11: flags hold with enable low (flags now 0111)
        step(4'd1, 16'h0000, 16'h0001, 1'b0, 16'hFFFF, 1'b0, 4'b0111, "R11 hold");
        step(4'd8, 16'h0000, 16'h0080, 1'b0, 16'h0080, 1'b1, 4'b0111, "R11 hold movi");

        // R12: undefined codes
        step(4'd9,  16'hFFFF, 16'h0001, 1'b1, 16'h0000, 1'b0, 4'b0111, "R12 op9");
        step(4'd15, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0, 4'b0111, "R12 op15");

        // R8: zero shift with high byte set leaves C set and V kept
        step(4'd6, 16'h0000, 16'hFF00, 1'b1, 16'h0000, 1'b1, 4'b0111, "R8 zero amt");

        // R1: reset mid-run clears flags
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", {12'd0, flags}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule